// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the sending side of an asynchronous serial port. A one-character holding register sits in front of a shift register. Software can therefore load the next character while the current one is still leaving the line. A one-clock pacing strobe, `sampleTick`, marks each bit time; the bit-rate generator that produces it is outside the block. Every character goes out as a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits.

Three signals show progress. `bufEmpty` says whether the holding register can take a character. `emptyPulse` is a one-clock event for an interrupt or DMA request, and it fires at the moment a character moves into the shifter. `txBusy` stays high from the first start bit until the last queued character has finished. While the holding register is kept full in time, frames follow each other with no idle bit time between them.

The framing inputs (`len8`, `parityOn`, `parityOdd`, `twoStop`) are expected to stay stable while a character is in flight.

Top module: `serialTxBuffered`

## Requirements
- R1: After reset, `serialOut` is 1, `bufEmpty` is 1, `txBusy` is 0 and `emptyPulse` is 0.
- R2: A clock with `wrValid` high stores `wrData` and drives `bufEmpty` to 0 from the next cycle. Until a `sampleTick` arrives, `serialOut` and `txBusy` do not change.
- R3: When a `sampleTick` finds the shifter idle, `txEnable` high and a character held, the cycle after that clock edge shows `serialOut`=0 (start bit), `bufEmpty`=1, `txBusy`=1 and `emptyPulse`=1. `emptyPulse` is high for exactly one cycle.
- R4: Each later `sampleTick` sends one data bit, least significant bit first. With `len8`=1 bits 0..7 are sent. With `len8`=0 only bits 0..6 are sent and bit 7 of the character is ignored.
- R5: With `parityOn`=1, one extra bit follows the last data bit. It equals the XOR of the data bits actually sent, XORed with `parityOdd` (0 gives even parity, 1 gives odd). With `parityOn`=0 no such bit is sent.
- R6: The stop field is one high bit when `twoStop`=0 and two high bits when `twoStop`=1. The `sampleTick` that ends the stop field returns the line to idle high, and `txBusy` is 0 from the next cycle, unless a character is waiting.
- R7: If a character is held when the stop field ends, that same tick begins its start bit with no idle bit time. `txBusy` stays 1 throughout, and `emptyPulse` fires again.
- R8: While `txEnable` is 0, no character is taken from the holding register and the held character stays held. Dropping `txEnable` during a frame makes `serialOut` 1 and `txBusy` 0 from the next cycle.
- R9: While `txEnable` stays high, `serialOut` changes only in the cycle that follows a `sampleTick`.
- R10: Whenever `txBusy` is 0, `serialOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmit enable; low aborts and blocks loading |
| sampleTick | input | 1 | One-clock bit-time pacing strobe |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | DATA_W | Character to send |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| parityOn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| twoStop | input | 1 | 1: two stop bits, 0: one |
| serialOut | output | 1 | Serial line, idle high |
| bufEmpty | output | 1 | Holding register can accept a character |
| emptyPulse | output | 1 | One-clock event when a character enters the shifter |
| txBusy | output | 1 | A frame is in progress |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. The line is high whenever the block is not busy. The line moves only after a pacing tick. The empty event lasts one cycle and always coincides with a start bit. Dropping the enable idles the block on the next cycle. The bit counter never runs past the selected character length. What the assertions cannot show is the content of each frame. The directed scenarios cover that: the exact order of data, parity and stop bits for several lengths and parity settings, bit 7 being dropped in 7-bit mode, back-to-back frames with no idle bit time, and a held character surviving while the enable is low.

// File: rtl/serialTxPkg.sv
package serialTxPkg;
  // Strobes issued by the control FSM to the datapath, valid for one clock
  typedef struct packed {
    logic load;    // copy holding register into shifter, drive start bit
    logic shift;   // drive next data bit and advance shifter
    logic parity;  // drive stored parity bit
    logic mark;    // drive line high (stop or idle)
  } txStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } txState_e;
endpackage

// File: rtl/serialTxCtrl.sv
module serialTxCtrl
  import serialTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      sampleTick,
  input  logic      holdFull,
  input  logic      len8,
  input  logic      parityOn,
  input  logic      twoStop,
  output txStrobe_t strobe,
  output logic      busy
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  txState_e        state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic            stopCnt, stopCntNext;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx = len8 ? LAST_LONG : LAST_SHORT;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe      = '0;
    stateNext   = state;
    bitCntNext  = bitCnt;
    stopCntNext = stopCnt;
    if (!txEnable) begin
      strobe.mark = 1'b1;
      stateNext   = ST_IDLE;
    end else if (sampleTick) begin
      unique case (state)
        ST_IDLE: begin
          if (holdFull) begin
            strobe.load = 1'b1;
            stateNext   = ST_START;
          end
        end
        ST_START: begin
          strobe.shift = 1'b1;
          bitCntNext   = '0;
          stateNext    = ST_DATA;
        end
        ST_DATA: begin
          if (bitCnt == lastIdx) begin
            stopCntNext = 1'b0;
            if (parityOn) begin
              strobe.parity = 1'b1;
              stateNext     = ST_PARITY;
            end else begin
              strobe.mark = 1'b1;
              stateNext   = ST_STOP;
            end
          end else begin
            strobe.shift = 1'b1;
            bitCntNext   = bitCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          strobe.mark = 1'b1;
          stopCntNext = 1'b0;
          stateNext   = ST_STOP;
        end
        ST_STOP: begin
          if (stopCnt || !twoStop) begin
            if (holdFull) begin
              strobe.load = 1'b1;
              stateNext   = ST_START;
            end else begin
              strobe.mark = 1'b1;
              stateNext   = ST_IDLE;
            end
          end else begin
            strobe.mark = 1'b1;
            stopCntNext = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      stopCnt <= 1'b0;
    end else begin
      state   <= stateNext;
      bitCnt  <= bitCntNext;
      stopCnt <= stopCntNext;
    end
  end

  // R8
  enable_drop_idles_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !busy);

  // R4
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitCnt <= lastIdx));

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.shift, strobe.parity, strobe.mark}));
endmodule

// File: rtl/serialTxData.sv
module serialTxData
  import serialTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              len8,
  input  logic              parityOdd,
  output logic              serialOut,
  output logic              holdFull,
  output logic              emptyPulse
);
  localparam logic [DATA_W-1:0] MASK_LONG  = '1;
  localparam logic [DATA_W-1:0] MASK_SHORT = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic              lineReg;
  logic [DATA_W-1:0] sentMask;

  assign sentMask  = len8 ? MASK_LONG : MASK_SHORT;
  assign serialOut = lineReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg    <= '0;
      holdFull   <= 1'b0;
      shiftReg   <= '0;
      parityBit  <= 1'b0;
      lineReg    <= 1'b1;
      emptyPulse <= 1'b0;
    end else begin
      emptyPulse <= strobe.load;
      if (wrValid) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (strobe.load) begin
        holdFull <= 1'b0;
      end
      if (strobe.load) begin
        shiftReg  <= holdReg;
        parityBit <= ^(holdReg & sentMask) ^ parityOdd;
        lineReg   <= 1'b0;
      end else if (strobe.shift) begin
        lineReg  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strobe.parity) begin
        lineReg <= parityBit;
      end else if (strobe.mark) begin
        lineReg <= 1'b1;
      end
    end
  end

  // R3
  empty_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyPulse |=> !emptyPulse);

  // R3
  empty_with_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyPulse |-> !serialOut);
endmodule

// File: rtl/serialTxBuffered.sv
module serialTxBuffered
  import serialTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              sampleTick,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              len8,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  output logic              serialOut,
  output logic              bufEmpty,
  output logic              emptyPulse,
  output logic              txBusy
);
  txStrobe_t strobe;
  logic      holdFull;

  serialTxCtrl #(.DATA_W(DATA_W)) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnable   (txEnable),
    .sampleTick (sampleTick),
    .holdFull   (holdFull),
    .len8       (len8),
    .parityOn   (parityOn),
    .twoStop    (twoStop),
    .strobe     (strobe),
    .busy       (txBusy)
  );

  serialTxData #(.DATA_W(DATA_W)) data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrValid    (wrValid),
    .wrData     (wrData),
    .len8       (len8),
    .parityOdd  (parityOdd),
    .serialOut  (serialOut),
    .holdFull   (holdFull),
    .emptyPulse (emptyPulse)
  );

  assign bufEmpty = !holdFull;

  // R10
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> serialOut);

  // R9
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(sampleTick) && $past(txEnable) && txEnable) |-> $stable(serialOut));
endmodule

// File: tb/serialTxBuffered_test.sv
`timescale 1ns/1ps
module serialTxBuffered_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b1;
  logic       sampleTick = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       len8 = 1'b1;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       serialOut, bufEmpty, emptyPulse, txBusy;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serialTxBuffered #(.DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .sampleTick(sampleTick),
    .wrValid(wrValid), .wrData(wrData), .len8(len8), .parityOn(parityOn),
    .parityOdd(parityOdd), .twoStop(twoStop), .serialOut(serialOut),
    .bufEmpty(bufEmpty), .emptyPulse(emptyPulse), .txBusy(txBusy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk) begin wrValid = 1'b1; wrData = d; end
    @(negedge clk) wrValid = 1'b0;
  endtask

  // Sends one frame tick by tick and checks every bit against a model
  task automatic shiftFrame(input logic [7:0] d, input bit chained,
                            input bit writeNext, input logic [7:0] nextD);
    logic exp [0:11];
    int   n = len8 ? 8 : 7;
    int   k = 0;
    logic p = parityOdd;
    exp[k++] = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp[k++] = d[i];
      p ^= d[i];
    end
    if (parityOn) exp[k++] = p;
    exp[k++] = 1'b1;
    if (twoStop) exp[k++] = 1'b1;
    for (int j = 0; j < k; j++) begin
      tick();
      chk((j == 0) ? "R3 start" : (j <= n) ? "R4 data" :
          (parityOn && j == n + 1) ? "R5 parity" : "R6 stop", serialOut, exp[j]);
      chk("R7 busy held", txBusy, 1'b1);
      if (j == 0) begin
        chk("R3 pulse", emptyPulse, 1'b1);
        chk("R3 empty", bufEmpty, 1'b1);
        @(negedge clk);
        chk("R3 pulse single", emptyPulse, 1'b0);
        chk("R9 stable", serialOut, exp[0]);
        if (writeNext) begin
          writeChar(nextD);
          chk("R2 full", bufEmpty, 1'b0);
        end
      end
    end
    if (!chained) begin
      tick();
      chk("R6 idle line", serialOut, 1'b1);
      chk("R6 busy low", txBusy, 1'b0);
    end
  endtask

  task automatic testReset();
    chk("R1 line", serialOut, 1'b1);
    chk("R1 empty", bufEmpty, 1'b1);
    chk("R1 busy", txBusy, 1'b0);
    chk("R1 pulse", emptyPulse, 1'b0);
  endtask

  task automatic testWriteHold();
    len8 = 1; parityOn = 0; twoStop = 0;
    writeChar(8'hA5);
    chk("R2 full", bufEmpty, 1'b0);
    repeat (4) @(negedge clk);
    chk("R2 line unchanged", serialOut, 1'b1);
    chk("R2 busy unchanged", txBusy, 1'b0);
    shiftFrame(8'hA5, 0, 0, 8'h00);
  endtask

  task automatic testSevenBitParity();
    len8 = 0; parityOn = 1; parityOdd = 0; twoStop = 0;
    writeChar(8'h55);
    shiftFrame(8'h55, 0, 0, 8'h00);
    parityOdd = 1;
    writeChar(8'hFF);  // R4: bit 7 must be dropped
    shiftFrame(8'hFF, 0, 0, 8'h00);
  endtask

  task automatic testTwoStopOdd();
    len8 = 1; parityOn = 1; parityOdd = 1; twoStop = 1;
    writeChar(8'h3C);
    shiftFrame(8'h3C, 0, 0, 8'h00);
  endtask

  task automatic testBackToBack();
    len8 = 1; parityOn = 0; twoStop = 0;
    writeChar(8'h81);
    shiftFrame(8'h81, 1, 1, 8'h6E);
    shiftFrame(8'h6E, 0, 0, 8'h00);  // R7: start on stop-ending tick
  endtask

  task automatic testEnable();
    len8 = 1; parityOn = 0; twoStop = 0;
    txEnable = 0;
    writeChar(8'h34);
    repeat (3) tick();
    chk("R8 line idle", serialOut, 1'b1);
    chk("R8 not busy", txBusy, 1'b0);
    chk("R8 char held", bufEmpty, 1'b0);
    chk("R8 no pulse", emptyPulse, 1'b0);
    txEnable = 1;
    tick();
    chk("R8 held start", serialOut, 1'b0);
    tick(); chk("R8 bit0", serialOut, 1'b0);
    tick(); chk("R8 bit1", serialOut, 1'b0);
    tick(); chk("R8 bit2", serialOut, 1'b1);
    tick(); chk("R8 bit3", serialOut, 1'b0);
    @(negedge clk) txEnable = 0;
    @(negedge clk);
    chk("R8 abort line", serialOut, 1'b1);
    chk("R8 abort busy", txBusy, 1'b0);
    txEnable = 1;
    tick();
    chk("R10 stays idle", serialOut, 1'b1);
    chk("R8 stays idle", txBusy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteHold();
    testSevenBitParity();
    testTwoStopOdd();
    testBackToBack();
    testEnable();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule